// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Change Register

This block holds the 32-bit status word for one downstream port of a USB host root hub. The lower half reports the live state of the port: whether a device is attached, and whether the port is enabled, suspended, in reset, powered, or driving a low-speed device. It also reports the over-current level. The port state logic drives these levels. The block registers them and shows them to software through a register bus whose read and write strobes arrive already decoded.

The upper half holds five sticky change flags. Each flag latches when its port event occurs:

- the device attachment changes;
- hardware drops the port enable;
- a selective resume finishes;
- the over-current level toggles;
- reset signalling completes.

Software clears a flag by writing 1 to its bit. A single interrupt line stays high while any flag is set. The over-current input arrives asynchronously, so it passes through a two-flop synchronizer before the block uses it. Entering the host controller's USB reset state clears the whole word.

Top module: `rh_port_status_reg`

## Requirements
- R1: While `rst` or `usb_rst_i` is high at a clock edge, every internal register clears. After that edge the register reads 0x00000000 and `chg_irq_o` is 0.
- R2: Bit 0 (attached) shows `connect_i` as registered at the previous edge. Any change of `connect_i` sets change bit 16.
- R3: Bits 1, 2, 4, 8 and 9 show, one edge late, `enabled_i`, `suspended_i`, `resetting_i`, `powered_i` and `low_speed_i` in that order. Bits 7:5, 15:10 and 31:21 always read 0.
- R4: Bit 3 shows `ovc_i` after a two-flop synchronizer. Each toggle of the synchronized level sets change bit 19.
- R5: A one-cycle pulse sets a change bit: `reset_done_i` sets bit 20, `resume_done_i` sets bit 18, and `hw_disable_i` sets bit 17. No software write can set bit 17.
- R6: When a write carries a 1 in any of bits 20:16, the matching change bit clears. A 0 in those positions leaves the bit unchanged.
- R7: When a set event and a write-1 clear hit the same change bit in the same cycle, the bit ends up set.
- R8: Writes have no effect on bits 15:0 or 31:21.
- R9: `chg_irq_o` is high exactly when at least one change bit in 20:16 is set.
- R10: At the edge where `rd_en` is high, `rdata_o` loads the register word. At every other edge outside reset, `rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_rst_i | input | 1 | Host controller is in the USB reset state; clears the word |
| rd_en | input | 1 | Decoded read strobe |
| wr_en | input | 1 | Decoded write strobe |
| wdata_i | input | 32 | Write data; 1s in bits 20:16 clear flags |
| rdata_o | output | 32 | Registered read data |
| connect_i | input | 1 | Device attached level |
| enabled_i | input | 1 | Port enabled level |
| suspended_i | input | 1 | Port suspended level |
| resetting_i | input | 1 | Port reset signalling active |
| powered_i | input | 1 | Port power on |
| low_speed_i | input | 1 | Low-speed device attached |
| ovc_i | input | 1 | Asynchronous over-current indicator |
| reset_done_i | input | 1 | Pulse: reset signalling completed |
| resume_done_i | input | 1 | Pulse: selective resume completed |
| hw_disable_i | input | 1 | Pulse: hardware cleared the port enable |
| chg_irq_o | output | 1 | High while any change flag is set |

## Verification
Live levels and event pulses reach the internal word at the first edge after they are applied. The attach flag and bit 0 follow the same timing. A read strobe issued one cycle later returns the new word at the next edge. Over-current takes three edges to set its change flag, so the bench waits four cycles before reading it. Each read pushes its expected word into a queue. A monitor pops that entry on the falling edge after the capturing edge and compares it. Interrupt-line checks are also made on falling edges, one edge after the causing event.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned CHG_N   = 5;
    localparam int unsigned CHG_LSB = 16;
    localparam int unsigned SYNC_N  = 2;

    // change-flag indices (bit = CHG_LSB + index)
    localparam int unsigned CI_CONN = 0;
    localparam int unsigned CI_EN   = 1;
    localparam int unsigned CI_SUSP = 2;
    localparam int unsigned CI_OVC  = 3;
    localparam int unsigned CI_RST  = 4;

    typedef struct packed {
        logic lsda;
        logic pps;
        logic prs;
        logic poci;
        logic pss;
        logic pes;
        logic ccs;
    } port_stat_t;

    function automatic logic [REG_W-1:0] pack_word(input port_stat_t s,
                                                   input logic [CHG_N-1:0] c);
        logic [REG_W-1:0] w;
        w = '0;
        w[0] = s.ccs;
        w[1] = s.pes;
        w[2] = s.pss;
        w[3] = s.poci;
        w[4] = s.prs;
        w[8] = s.pps;
        w[9] = s.lsda;
        w[CHG_LSB +: CHG_N] = c;
        return w;
    endfunction
endpackage

// File: rtl/rhp_ovc_sync.sv
module rhp_ovc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic async_i,
    output logic level_o,
    output logic toggle_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (clr) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (clr) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign level_o  = chain_q[STAGES-1];
    assign toggle_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/rhp_chg_bits.sv
module rhp_chg_bits #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [N-1:0] set_i,
    input  logic         wr_en,
    input  logic [N-1:0] w1c_i,
    output logic [N-1:0] flags_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_flag
            logic f_q;
            always_ff @(posedge clk) begin
                if (clr)                    f_q <= 1'b0;
                else if (set_i[g])          f_q <= 1'b1;   // set beats clear
                else if (wr_en && w1c_i[g]) f_q <= 1'b0;
            end
            assign flags_o[g] = f_q;
        end
    endgenerate
endmodule

// File: rtl/rh_port_status_reg.sv
module rh_port_status_reg
    import rhp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             usb_rst_i,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    input  logic             connect_i,
    input  logic             enabled_i,
    input  logic             suspended_i,
    input  logic             resetting_i,
    input  logic             powered_i,
    input  logic             low_speed_i,
    input  logic             ovc_i,
    input  logic             reset_done_i,
    input  logic             resume_done_i,
    input  logic             hw_disable_i,
    output logic             chg_irq_o
);
    logic             clr;
    port_stat_t       stat_q;
    logic             ovc_level;
    logic             ovc_toggle;
    logic [CHG_N-1:0] chg_set;
    logic [CHG_N-1:0] chg_flags;

    assign clr = rst | usb_rst_i;

    rhp_ovc_sync #(.STAGES(SYNC_N)) u_ovc (
        .clk      (clk),
        .clr      (clr),
        .async_i  (ovc_i),
        .level_o  (ovc_level),
        .toggle_o (ovc_toggle)
    );

    // live status capture; ccs doubles as the previous connect sample
    always_ff @(posedge clk) begin
        if (clr) begin
            stat_q <= '0;
        end else begin
            stat_q.ccs  <= connect_i;
            stat_q.pes  <= enabled_i;
            stat_q.pss  <= suspended_i;
            stat_q.poci <= ovc_level;
            stat_q.prs  <= resetting_i;
            stat_q.pps  <= powered_i;
            stat_q.lsda <= low_speed_i;
        end
    end

    always_comb begin
        chg_set          = '0;
        chg_set[CI_CONN] = connect_i ^ stat_q.ccs;
        chg_set[CI_EN]   = hw_disable_i;
        chg_set[CI_SUSP] = resume_done_i;
        chg_set[CI_OVC]  = ovc_toggle;
        chg_set[CI_RST]  = reset_done_i;
    end

    rhp_chg_bits #(.N(CHG_N)) u_chg (
        .clk     (clk),
        .clr     (clr),
        .set_i   (chg_set),
        .wr_en   (wr_en),
        .w1c_i   (wdata_i[CHG_LSB +: CHG_N]),
        .flags_o (chg_flags)
    );

    always_ff @(posedge clk) begin
        if (clr)        rdata_o <= '0;
        else if (rd_en) rdata_o <= pack_word(stat_q, chg_flags);
    end

    assign chg_irq_o = |chg_flags;
endmodule

// File: rtl/rh_port_status_reg_chk.sv
module rh_port_status_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        usb_rst_i,
    input logic        rd_en,
    input logic        wr_en,
    input logic        reset_done_i,
    input logic [31:0] rdata_o,
    input logic        chg_irq_o
);
    assert_usb_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(usb_rst_i) && !$past(rst)) |-> (rdata_o == 32'h0 && !chg_irq_o));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rdata_o[31:21] == '0 && rdata_o[15:10] == '0 && rdata_o[7:5] == '0));

    assert_irq_falls_on_write_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(chg_irq_o)) |-> ($past(wr_en) || $past(usb_rst_i)));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(reset_done_i) && !$past(usb_rst_i) && !$past(rst)) |-> chg_irq_o);

    assert_read_matches_irq_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && !$past(usb_rst_i) && !$past(rst))
            |-> ((rdata_o[20:16] != '0) == $past(chg_irq_o)));

    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rd_en) && !$past(usb_rst_i) && !$past(rst)) |-> $stable(rdata_o));
endmodule

bind rh_port_status_reg rh_port_status_reg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .usb_rst_i    (usb_rst_i),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .reset_done_i (reset_done_i),
    .rdata_o      (rdata_o),
    .chg_irq_o    (chg_irq_o)
);

// File: tb/rh_port_status_reg_tb_top.sv
`timescale 1ns/1ps
module rh_port_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        usb_rst_i = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic connect_i = 0, enabled_i = 0, suspended_i = 0, resetting_i = 0;
    logic powered_i = 0, low_speed_i = 0, ovc_i = 0;
    logic reset_done_i = 0, resume_done_i = 0, hw_disable_i = 0;
    logic chg_irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    rh_port_status_reg dut_i (.*);

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // driver: issue a read and queue the expected word
    task automatic rd_expect(input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        tick();
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1;
        wdata_i = v;
        tick();
        wr_en = 1'b0;
        wdata_i = '0;
    endtask

    // monitor: compare on the falling edge after the capture edge
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("R10 unexpected read", 32'h1, 32'h0);
                end else begin
                    check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        check("R1 irq after reset", {31'b0, chg_irq_o}, 32'h0);
        rd_expect(32'h0, "R1 word after reset");

        // live status bits
        enabled_i = 1; suspended_i = 1; resetting_i = 1; powered_i = 1; low_speed_i = 1;
        tick();
        rd_expect(32'h0000_0316, "R3 status layout");
        enabled_i = 0; suspended_i = 0; resetting_i = 0; low_speed_i = 0;
        tick();
        rd_expect(32'h0000_0100, "R3 power only");
        powered_i = 0;
        tick();

        // attach
        connect_i = 1;
        tick();
        check("R9 irq on attach", {31'b0, chg_irq_o}, 32'h1);
        rd_expect(32'h0001_0001, "R2 attach sets CCS and CSC");
        wr(32'h0001_0000);
        rd_expect(32'h0000_0001, "R6 w1c CSC");
        check("R9 irq clear", {31'b0, chg_irq_o}, 32'h0);

        // reset completion, write-0 and non-change writes
        reset_done_i = 1; tick(); reset_done_i = 0;
        rd_expect(32'h0010_0001, "R5 PRSC set");
        wr(32'h0);
        rd_expect(32'h0010_0001, "R6 write 0 keeps flag");
        wr(32'hFFE0_FFFF);
        rd_expect(32'h0010_0001, "R8 non-change write ignored");
        wr(32'h0010_0000);
        rd_expect(32'h0000_0001, "R6 w1c PRSC");

        // resume completion and hardware disable
        resume_done_i = 1; tick(); resume_done_i = 0;
        hw_disable_i = 1; tick(); hw_disable_i = 0;
        rd_expect(32'h0006_0001, "R5 PSSC and PESC set");
        wr(32'h0002_0000);
        rd_expect(32'h0004_0001, "R6 selective clear");
        wr(32'h0004_0000);
        rd_expect(32'h0000_0001, "R6 clear PSSC");

        // over-current both directions
        ovc_i = 1; tick(4);
        rd_expect(32'h0008_0009, "R4 over-current rise");
        wr(32'h0008_0000);
        rd_expect(32'h0000_0009, "R4 OCIC clear keeps POCI");
        ovc_i = 0; tick(4);
        rd_expect(32'h0008_0001, "R4 over-current fall");
        wr(32'h0008_0000);
        tick();

        // set wins over simultaneous clear
        reset_done_i = 1; wr_en = 1; wdata_i = 32'h0010_0000;
        tick();
        reset_done_i = 0; wr_en = 0; wdata_i = '0;
        rd_expect(32'h0010_0001, "R7 set beats clear");
        wr(32'h0010_0000);

        // read data holds without a strobe
        rd_expect(32'h0000_0001, "R10 baseline read");
        powered_i = 1; tick(3);
        check("R10 rdata held", rdata_o, 32'h0000_0001);
        powered_i = 0;

        // USB reset state clears all
        connect_i = 0; tick();
        resume_done_i = 1; tick(); resume_done_i = 0;
        check("R9 irq before usb reset", {31'b0, chg_irq_o}, 32'h1);
        usb_rst_i = 1; tick(2); usb_rst_i = 0;
        check("R1 irq after usb reset", {31'b0, chg_irq_o}, 32'h0);
        rd_expect(32'h0, "R1 word after usb reset");

        tick(2);
        check("R10 queue drained", exp_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule